// File: doc/BRIEF.md
# Dual-Match Reloading Down-Counter Channel

This block is a single timer channel. While enabled it counts down by one on each tick of a selected rate, and after sitting at zero it reloads a programmable start value on the next tick, so it repeats indefinitely. On every decrement the value it lands on is compared against two match registers, which may be programmed in either order, and against zero. Each such event inverts a level-type interrupt output rather than producing a pulse.

The channel receives already decoded register writes: a shared data word with four write strobes (count, reload, first match, second match), plus three control levels (channel enable, tick source select, zero-event enable). Two tick strobes come in from outside: a fast one at the bus rate and a slow one at an external rate. The running count and the interrupt level are the only outputs.

Top module: `tmr_dual_match_chan`

## Requirements
- R1: After reset the count and interrupt level are 0, and the reload value and both match values are 0.
- R2: While enabled, each selected tick lowers a nonzero count by exactly one; cycles without a selected tick leave the count unchanged.
- R3: With `src_slow_i` = 0 only `tick_fast_i` advances the channel; with `src_slow_i` = 1 only `tick_slow_i` does.
- R4: A selected tick while the count is 0 loads the reload value into the count and raises no event.
- R5: A decrement that lands on either match value inverts `irq_level_o` once, whichever of the two match registers holds the larger value.
- R6: A decrement that lands on 0 inverts `irq_level_o` only when `zero_irq_en_i` = 1 or either match value is 0.
- R7: When both match values are equal, landing on that value inverts `irq_level_o` once, not twice.
- R8: In the first enabled cycle after a disabled one, the count is loaded with the reload value and no event occurs; while disabled, the count and interrupt level hold and ticks have no effect.
- R9: A count write while enabled (and not in the first enabled cycle) loads `wr_data_i` into the count, with no decrement or event in that cycle; a count write while disabled is ignored.
- R10: Reload and match writes are accepted at any time; a match write is used from the next cycle, including within the current period.
- R11: With a reload value of 0 the channel, once at zero, stays at zero and raises no events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fast_i | input | 1 | One-cycle strobe at the fast bus rate |
| tick_slow_i | input | 1 | One-cycle strobe at the slow external rate |
| chan_en_i | input | 1 | Channel enable level |
| src_slow_i | input | 1 | Tick source select: 0 fast, 1 slow |
| zero_irq_en_i | input | 1 | Allows the zero event to toggle the interrupt |
| wr_count_i | input | 1 | Write strobe for the count |
| wr_reload_i | input | 1 | Write strobe for the reload value |
| wr_match_a_i | input | 1 | Write strobe for the first match value |
| wr_match_b_i | input | 1 | Write strobe for the second match value |
| wr_data_i | input | CNT_W | Data shared by all write strobes |
| count_o | output | CNT_W | Current count |
| irq_level_o | output | 1 | Interrupt level, inverted on each event |

## Verification
The assertions assume the tick strobes and control levels are synchronous to `clk` and free of unknown values whenever reset is released, and that a count write is the only way the count jumps outside its step-down or reload path. The stimulus drives every input on the falling edge from one task, holds the control levels steady between calls, and never leaves a strobe undriven. Match values and reload values are chosen so that each decrement path, the zero gate, equal matches and a zero reload are all reached within short runs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Tick source indices; the select input is the index.
    localparam int SRC_FAST   = 0;
    localparam int SRC_SLOW   = 1;
    localparam int N_TICK_SRC = 2;

    // Kind of event raised by one decrement.
    typedef enum logic [1:0] {
        EVT_NONE  = 2'd0,
        EVT_UPPER = 2'd1,
        EVT_LOWER = 2'd2,
        EVT_ZERO  = 2'd3
    } evt_e;

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
    parameter  int N_SRC = 2,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] strobe_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel_i == SEL_W'(i)) begin
                tick_o = strobe_i[i];
            end
        end
    end

endmodule

// File: rtl/tmr_match_sort.sv
module tmr_match_sort #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] match_a_i,
    input  logic [CNT_W-1:0] match_b_i,
    output logic [CNT_W-1:0] hi_o,
    output logic [CNT_W-1:0] lo_o,
    output logic             has_zero_o
);

    logic a_bigger;

    always_comb begin
        a_bigger   = (match_a_i > match_b_i);
        hi_o       = a_bigger ? match_a_i : match_b_i;
        lo_o       = a_bigger ? match_b_i : match_a_i;
        // The smaller value is zero exactly when either value is zero.
        has_zero_o = (lo_o == '0);
    end

endmodule

// File: rtl/tmr_evt_detect.sv
module tmr_evt_detect
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             step_i,
    input  logic [CNT_W-1:0] land_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic             has_zero_i,
    input  logic             zero_en_i,
    output evt_e             kind_o
);

    always_comb begin
        kind_o = EVT_NONE;
        if (step_i) begin
            if (land_i == '0) begin
                // A zero match value also opens the zero gate; one event only.
                if (zero_en_i || has_zero_i) begin
                    kind_o = EVT_ZERO;
                end
            end else if (land_i == lo_i) begin
                // Equal match values land here once.
                kind_o = EVT_LOWER;
            end else if (land_i == hi_i) begin
                kind_o = EVT_UPPER;
            end
        end
    end

endmodule

// File: rtl/tmr_dual_match_chan.sv
module tmr_dual_match_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast_i,
    input  logic             tick_slow_i,
    input  logic             chan_en_i,
    input  logic             src_slow_i,
    input  logic             zero_irq_en_i,
    input  logic             wr_count_i,
    input  logic             wr_reload_i,
    input  logic             wr_match_a_i,
    input  logic             wr_match_b_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_level_o
);

    localparam int SEL_W = (N_TICK_SRC > 1) ? $clog2(N_TICK_SRC) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] match_a;
        logic [CNT_W-1:0] match_b;
        logic             irq;
        logic             en;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic [N_TICK_SRC-1:0] strobes;
    logic [SEL_W-1:0]      tick_sel;
    logic                  tick;
    logic [CNT_W-1:0]      m_hi, m_lo;
    logic                  m_has_zero;
    logic [CNT_W-1:0]      land;
    logic                  step;
    logic                  en_first;
    evt_e                  evt_kind;

    always_comb begin
        strobes           = '0;
        strobes[SRC_FAST] = tick_fast_i;
        strobes[SRC_SLOW] = tick_slow_i;
        tick_sel          = SEL_W'(src_slow_i);
    end

    tmr_tick_sel #(
        .N_SRC (N_TICK_SRC)
    ) u_tick_sel (
        .strobe_i (strobes),
        .sel_i    (tick_sel),
        .tick_o   (tick)
    );

    tmr_match_sort #(
        .CNT_W (CNT_W)
    ) u_sort (
        .match_a_i  (st_q.match_a),
        .match_b_i  (st_q.match_b),
        .hi_o       (m_hi),
        .lo_o       (m_lo),
        .has_zero_o (m_has_zero)
    );

    always_comb begin
        en_first = chan_en_i && !st_q.en;
        land     = st_q.count - 1'b1;
        step     = chan_en_i && st_q.en && !wr_count_i && tick && (st_q.count != '0);
    end

    tmr_evt_detect #(
        .CNT_W (CNT_W)
    ) u_evt (
        .step_i     (step),
        .land_i     (land),
        .hi_i       (m_hi),
        .lo_i       (m_lo),
        .has_zero_i (m_has_zero),
        .zero_en_i  (zero_irq_en_i),
        .kind_o     (evt_kind)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = chan_en_i;

        if (wr_reload_i)  st_d.reload  = wr_data_i;
        if (wr_match_a_i) st_d.match_a = wr_data_i;
        if (wr_match_b_i) st_d.match_b = wr_data_i;

        if (en_first) begin
            st_d.count = st_q.reload;
        end else if (chan_en_i) begin
            if (wr_count_i) begin
                st_d.count = wr_data_i;
            end else if (step) begin
                st_d.count = land;
                if (evt_kind != EVT_NONE) begin
                    st_d.irq = ~st_q.irq;
                end
            end else if (tick) begin
                // Count is zero here: restart the period, no event.
                st_d.count = st_q.reload;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o     = st_q.count;
    assign irq_level_o = st_q.irq;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_fast_i,
    input logic             tick_slow_i,
    input logic             chan_en_i,
    input logic             src_slow_i,
    input logic             wr_count_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_level_o
);

    logic en_prev;
    logic sel_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= chan_en_i;
    end

    assign sel_tick = src_slow_i ? tick_slow_i : tick_fast_i;

    // R8: a disabled cycle leaves the count alone.
    p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en_i |=> $stable(count_o));

    // R2: a running, nonzero count steps down by one per selected tick.
    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en_i && en_prev && !wr_count_i && sel_tick && (count_o != '0))
        |=> ((count_o + 1'b1) == $past(count_o)));

    // R9: a count write while running loads the written data.
    p_load_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en_i && en_prev && wr_count_i) |=> (count_o == $past(wr_data_i)));

    // R5: the interrupt level only moves on a selected tick while running.
    p_irq_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(chan_en_i && sel_tick) |=> $stable(irq_level_o));

    // R9: no event in a cycle that carries a count write.
    p_irq_quiet_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count_i |=> $stable(irq_level_o));

endmodule

bind tmr_dual_match_chan tmr_chan_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_fast_i (tick_fast_i),
    .tick_slow_i (tick_slow_i),
    .chan_en_i   (chan_en_i),
    .src_slow_i  (src_slow_i),
    .wr_count_i  (wr_count_i),
    .wr_data_i   (wr_data_i),
    .count_o     (count_o),
    .irq_level_o (irq_level_o)
);

// File: tb/sim_tmr_dual_match_chan.sv
module sim_tmr_dual_match_chan;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int WD_CYCLES  = 20000;

    typedef struct {
        logic [W-1:0] cnt;
        logic         irq;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tf = 1'b0, ts = 1'b0;
    logic         en = 1'b0, src = 1'b0, zen = 1'b0;
    logic         wrc = 1'b0, wrr = 1'b0, wra = 1'b0, wrb = 1'b0;
    logic [W-1:0] data = '0;
    logic [W-1:0] count_o;
    logic         irq_o;

    // bench-side levels, applied at the next falling edge
    logic b_en = 1'b0, b_src = 1'b0, b_zen = 1'b0;

    // expectation model state
    logic [W-1:0] m_cnt = '0, m_rel = '0, m_a = '0, m_b = '0;
    logic         m_irq = 1'b0, m_en = 1'b0;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_dual_match_chan #(.CNT_W(W)) u0 (
        .clk (clk), .rst_n (rst_n),
        .tick_fast_i (tf), .tick_slow_i (ts),
        .chan_en_i (en), .src_slow_i (src), .zero_irq_en_i (zen),
        .wr_count_i (wrc), .wr_reload_i (wrr),
        .wr_match_a_i (wra), .wr_match_b_i (wrb),
        .wr_data_i (data),
        .count_o (count_o), .irq_level_o (irq_o)
    );

    // Driver: drives one cycle and pushes the value expected after its edge.
    task automatic cyc(input logic f, input logic s, input logic c, input logic r,
                       input logic a, input logic b, input logic [W-1:0] d,
                       input string tag);
        logic   tick;
        logic [W-1:0] nxt;
        exp_t   e;
        @(negedge clk);
        tf = f; ts = s; wrc = c; wrr = r; wra = a; wrb = b; data = d;
        en = b_en; src = b_src; zen = b_zen;
        tick = b_src ? s : f;
        if (b_en) begin
            if (!m_en) begin
                m_cnt = m_rel;
            end else if (c) begin
                m_cnt = d;
            end else if (tick) begin
                if (m_cnt == '0) begin
                    m_cnt = m_rel;
                end else begin
                    nxt = m_cnt - 1'b1;
                    if ((nxt != '0 && (nxt == m_a || nxt == m_b)) ||
                        (nxt == '0 && (b_zen || m_a == '0 || m_b == '0)))
                        m_irq = ~m_irq;
                    m_cnt = nxt;
                end
            end
        end
        if (r) m_rel = d;
        if (a) m_a = d;
        if (b) m_b = d;
        m_en = b_en;
        e.cnt = m_cnt; e.irq = m_irq; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic run_fast(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic run_slow(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic wr_matches(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        cyc(0, 0, 0, 0, 1, 0, a, tag);
        cyc(0, 0, 0, 0, 0, 1, b, tag);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: pops one expectation per clock, just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (count_o !== e.cnt || irq_o !== e.irq) begin
                    errors++;
                    $display("FAIL %s: actual count=%0d irq=%0b expected count=%0d irq=%0b",
                             e.tag, count_o, irq_o, e.cnt, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual still running, expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs read as zero while reset is held
        checks++;
        if (count_o !== '0 || irq_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual count=%0d irq=%0b expected count=0 irq=0", count_o, irq_o);
        end
        rst_n = 1'b1;
        idle(2, "R1");
        // R11/R1: enabling with cleared reload keeps the count at zero, no events
        b_en = 1'b1;
        run_fast(6, "R11");
        // R8: disabled writes of reload and match values, count holds
        b_en = 1'b0;
        cyc(0, 0, 0, 1, 0, 0, 16'd10, "R8");
        wr_matches(16'd7, 16'd3, "R10");
        run_fast(2, "R8");
        b_en = 1'b1;
        idle(1, "R8");
        // R5/R4/R6: one full period plus, larger match in register A, zero gate closed
        run_fast(14, "R5");
        // R2: ticks on alternate cycles
        for (int i = 0; i < 10; i++) cyc(logic'(i % 2), 0, 0, 0, 0, 0, '0, "R2");
        // R3: slow source selected, fast strobes ignored
        b_src = 1'b1;
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0, '0, "R3");
        run_slow(5, "R3");
        b_src = 1'b0;
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, 0, '0, "R3");
        // R5: larger match now in register B
        wr_matches(16'd2, 16'd8, "R10");
        run_fast(12, "R5");
        // R6: zero gate opened by the enable input
        b_zen = 1'b1;
        run_fast(12, "R6");
        b_zen = 1'b0;
        // R7: equal match values
        wr_matches(16'd5, 16'd5, "R7");
        run_fast(12, "R7");
        // R6: zero gate opened by a zero match value
        wr_matches(16'd0, 16'd6, "R6");
        run_fast(12, "R6");
        // R8/R9: disabled, ticks and count writes have no effect
        b_en = 1'b0;
        run_fast(3, "R8");
        cyc(1, 0, 1, 0, 0, 0, 16'd4, "R9");
        idle(1, "R9");
        b_en = 1'b1;
        cyc(1, 0, 1, 0, 0, 0, 16'd4, "R8");
        // R9: count write while running, with and without a tick in the same cycle
        cyc(0, 0, 1, 0, 0, 0, 16'd4, "R9");
        run_fast(2, "R9");
        cyc(1, 0, 1, 0, 0, 0, 16'd9, "R9");
        run_fast(3, "R9");
        // R10: match write mid period takes effect this period
        cyc(0, 0, 0, 0, 0, 1, 16'd4, "R10");
        run_fast(8, "R10");
        // R11: reload cleared while running; the period drains then sticks at zero
        cyc(0, 0, 0, 1, 0, 0, 16'd0, "R11");
        run_fast(20, "R11");
        idle(3, "R11");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule